// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer for a simple 16-bit register bus. A 32-bit counter advances once per prescaled tick while the watchdog is enabled. Software keeps the system alive by writing a two-word refresh key, and it may change the configuration only after writing a separate two-word unlock key. After a good unlock, configuration writes are accepted for a limited number of clock cycles.

Each key pair must complete within a short gap. A broken sequence is a fault. So is a timeout, or a refresh that comes too early while window mode is on. Every fault produces a one-cycle reset request pulse and increments a reset counter. Interrupt-first mode raises an interrupt at the timeout and delays the reset request by one prescaled tick.

The block is accessed through byte addresses. Every register is 16 bits wide at an even offset. Reads are combinational.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset, the control register reads 0x01D3, the reset counter reads 0, and both `wdt_irq` and `wdt_rst_req` are low. The window value resets to 0x00000010, the timeout value to 0x004C4B40 and the prescaler to 0.
- R2: The unlock key is 0xC520 followed by 0xD928, both written to offset 0x0E. If the second word lands 1 to 20 cycles after the first, the configuration registers accept writes for the next 256 cycles. A write 256 cycles after the second word is accepted, and a write 257 cycles after it is ignored.
- R3: While locked, writes to control (0x00), timeout (0x04 high, 0x06 low), window (0x08 high, 0x0A low) and prescaler (0x16) leave their read-back values unchanged.
- R4: Certain writes to the unlock offset raise a fault. These are any value other than 0xC520, 0xD928 written without a pending first word, and a pending first word whose second word has not arrived by the 20th cycle. A late second word therefore causes two faults.
- R5: The refresh key is 0xA602 followed by 0xB480, both written to offset 0x0C, with the same 20-cycle limit. A good refresh clears the counter. Wrong or late words fault in the same way as under R4.
- R6: With prescaler value P at offset 0x16, the counter advances once every P+1 clock cycles. It is read at 0x10 (high half) and 0x12 (low half).
- R7: Control bit 0 enables the watchdog, and bit 2 selects interrupt-first mode. With bit 2 clear, a counter value of T or more causes a reset request. The request appears (P+1)*T+1 cycles after the enabling write, and the counter then reads 0.
- R8: With bit 2 set, `wdt_irq` rises (P+1)*T+1 cycles after the enabling write. The reset request follows (P+1)*T+max(P+1,2) cycles after that write, and it clears the interrupt.
- R9: Control bit 3 selects window mode. In this mode, a refresh completed while the counter is below the window value faults. A refresh at a count equal to or above the window value is accepted.
- R10: Clearing control bit 0 stops the counter.
- R11: Control bit 4 allows repeated unlocks. When it is 0, only the first unlock after reset works, and later writes to the unlock offset are ignored without a fault.
- R12: Each reset request pulse increments the reset counter at 0x14. Writing ones to that offset clears the matching bits, and this write needs no unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte address bits 4:1 (word index) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| wdt_irq | output | 1 | Interrupt ahead of reset (interrupt-first mode) |
| wdt_rst_req | output | 1 | One-cycle reset request per fault |

## Verification
The hardest cases to reach from the ports are the exact edges of the timing windows: the 20th versus the 21st cycle of a key gap, and the 256th versus the 257th cycle of the unlock window. The bench sweeps the key gap from 1 to 24 for both key pairs, placing a configuration write exactly on either side of the window's end. The interrupt-to-reset spacing depends on the prescaler phase. It is covered by a grid of prescaler 0..3, timeout 1..4 and both modes, and every latency is measured against the closed-form expressions.

// File: rtl/keyguard_wdt.sv
module keyguard_wdt #(
  parameter int          KEY_GAP       = 20,
  parameter int          UNLOCK_CYCLES = 256,
  parameter logic [15:0] CTL_INIT      = 16'h01D3,
  parameter logic [31:0] TMO_INIT      = 32'h004C_4B40,
  parameter logic [31:0] WIN_INIT      = 32'h0000_0010,
  parameter logic [15:0] PRE_INIT      = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [4:1]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        wdt_irq,
  output logic        wdt_rst_req
);
  localparam int GW = $clog2(KEY_GAP + 1);
  localparam int UW = $clog2(UNLOCK_CYCLES + 1);
  localparam logic [3:0] A_CTLH = 4'd0, A_CTLL = 4'd1, A_TMOH = 4'd2, A_TMOL = 4'd3;
  localparam logic [3:0] A_WINH = 4'd4, A_WINL = 4'd5, A_RFSH = 4'd6, A_UNLK = 4'd7;
  localparam logic [3:0] A_CNTH = 4'd8, A_CNTL = 4'd9, A_RCNT = 4'd10, A_PRE = 4'd11;
  localparam logic [1:0][15:0] KEY_A = {16'hC520, 16'hA602};
  localparam logic [1:0][15:0] KEY_B = {16'hD928, 16'hB480};
  localparam logic [1:0][3:0]  KEY_SLOT = {A_UNLK, A_RFSH};

  logic [15:0]   ctl, pre, pcnt, rcnt;
  logic [31:0]   tmo, win, cnt;
  logic [UW-1:0] ucnt;
  logic          used, irq_q, rst_q;
  logic [1:0]    kact, kdone, kerr;

  wire        cfg_wr   = bus_wr && (ucnt != '0);
  wire        en       = ctl[0];
  wire        tick     = en && (pcnt == pre);
  wire        hit      = en && (cnt >= tmo);
  wire        tmo_viol = hit && (!ctl[2] || (irq_q && tick));
  wire        win_viol = kdone[0] && ctl[3] && (cnt < win);
  wire        viol     = (|kerr) || tmo_viol || win_viol;
  wire [15:0] rclr     = (bus_wr && bus_addr == A_RCNT) ? bus_wdata : 16'h0;

  assign kact = {ctl[4] || !used, 1'b1};

  // index 0: refresh key, index 1: unlock key
  for (genvar g = 0; g < 2; g++) begin : g_key
    logic          armed;
    logic [GW-1:0] gap;
    wire slot_wr  = bus_wr && (bus_addr == KEY_SLOT[g]) && kact[g];
    wire first_w  = bus_wdata == KEY_A[g];
    wire deadline = armed && (gap == GW'(KEY_GAP - 1));
    assign kdone[g] = slot_wr && armed && (bus_wdata == KEY_B[g]);
    assign kerr[g]  = slot_wr ? (!first_w && !kdone[g]) : deadline;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed <= 1'b0;
        gap   <= '0;
      end else if (slot_wr) begin
        armed <= first_w;
        gap   <= '0;
      end else if (deadline) begin
        armed <= 1'b0;
      end else if (armed) begin
        gap <= gap + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= CTL_INIT;
      tmo   <= TMO_INIT;
      win   <= WIN_INIT;
      pre   <= PRE_INIT;
      cnt   <= '0;
      pcnt  <= '0;
      ucnt  <= '0;
      used  <= 1'b0;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
      rcnt  <= '0;
    end else begin
      rst_q <= viol;
      rcnt  <= (rcnt & ~rclr) + {15'd0, viol};

      if (viol || kdone[0])        irq_q <= 1'b0;
      else if (hit && ctl[2])      irq_q <= 1'b1;

      if (viol || kdone[0]) begin
        cnt  <= '0;
        pcnt <= '0;
      end else if (tick) begin
        cnt  <= cnt + 1'b1;
        pcnt <= '0;
      end else if (en) begin
        pcnt <= pcnt + 1'b1;
      end

      if (kdone[1]) begin
        ucnt <= UW'(UNLOCK_CYCLES);
        used <= 1'b1;
      end else if (ucnt != '0) begin
        ucnt <= ucnt - 1'b1;
      end

      if (cfg_wr) begin
        case (bus_addr)
          A_CTLH:  ctl         <= bus_wdata;
          A_TMOH:  tmo[31:16]  <= bus_wdata;
          A_TMOL:  tmo[15:0]   <= bus_wdata;
          A_WINH:  win[31:16]  <= bus_wdata;
          A_WINL:  win[15:0]   <= bus_wdata;
          A_PRE:   pre         <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTLH:  bus_rdata = ctl;
      A_CTLL:  bus_rdata = 16'h0;
      A_TMOH:  bus_rdata = tmo[31:16];
      A_TMOL:  bus_rdata = tmo[15:0];
      A_WINH:  bus_rdata = win[31:16];
      A_WINL:  bus_rdata = win[15:0];
      A_CNTH:  bus_rdata = cnt[31:16];
      A_CNTL:  bus_rdata = cnt[15:0];
      A_RCNT:  bus_rdata = rcnt;
      A_PRE:   bus_rdata = pre;
      default: bus_rdata = 16'h0;
    endcase
  end

  assign wdt_irq     = irq_q;
  assign wdt_rst_req = rst_q;
endmodule

// File: rtl/keyguard_wdt_chk.sv
module keyguard_wdt_chk #(
  parameter int UW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [4:1]    bus_addr,
  input logic          wdt_irq,
  input logic          wdt_rst_req,
  input logic [15:0]   ctl,
  input logic [15:0]   rcnt,
  input logic [31:0]   tmo,
  input logic [31:0]   win,
  input logic [31:0]   cnt,
  input logic [UW-1:0] ucnt
);
  // R3
  locked_win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd5 && ucnt == '0) |=> win[15:0] == $past(win[15:0]));

  // R8
  irq_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> $past(ctl[2]));

  // R10
  halted_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctl[0]) && !wdt_rst_req && cnt != 32'd0) |-> cnt == $past(cnt));

  // R7
  timeout_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0] && !ctl[2] && cnt >= tmo) |=> wdt_rst_req);

  // R12
  rstcount_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst_req && !$past(bus_wr && bus_addr == 4'd10)) |-> rcnt == $past(rcnt) + 16'd1);
endmodule

bind keyguard_wdt keyguard_wdt_chk #(.UW(UW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req), .ctl(ctl), .rcnt(rcnt),
  .tmo(tmo), .win(win), .cnt(cnt), .ucnt(ucnt)
);

// File: tb/keyguard_wdt_tb_top.sv
module keyguard_wdt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:1]  bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        wdt_irq, wdt_rst_req;
  int checks = 0, errors = 0, npulse = 0;

  localparam logic [4:0] O_CTL = 5'h00, O_TMOH = 5'h04, O_TMOL = 5'h06, O_WINH = 5'h08,
                         O_WINL = 5'h0A, O_RFSH = 5'h0C, O_UNLK = 5'h0E, O_CNTH = 5'h10,
                         O_CNTL = 5'h12, O_RCNT = 5'h14, O_PRE = 5'h16;

  keyguard_wdt dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (rst_n && wdt_rst_req) npulse++;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_addr = a[4:1]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a[4:1];
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(O_UNLK, 16'hC520); wr(O_UNLK, 16'hD928);
  endtask

  task automatic refresh();
    wr(O_RFSH, 16'hA602); wr(O_RFSH, 16'hB480);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v, a0, b0, winv;
    int p0, k, irq_k, lat, expl, expi;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    rd(O_CTL, v);  check("R1 ctl", v, 16'h01D3);
    rd(O_RCNT, v); check("R1 rstcount", v, 0);
    rd(O_WINL, v); check("R1 window", v, 16'h0010);
    rd(O_TMOL, v); check("R1 timeout low", v, 16'h4B40);
    check("R1 outputs", {wdt_irq, wdt_rst_req}, 0);

    // R3 locked writes ignored
    wr(O_WINL, 16'h0077); wr(O_CTL, 16'h0000); wr(O_PRE, 16'h0005);
    rd(O_WINL, v); check("R3 window", v, 16'h0010);
    rd(O_CTL, v);  check("R3 ctl", v, 16'h01D3);
    rd(O_PRE, v);  check("R3 prescaler", v, 0);
    winv = 16'h0010;

    // R2 / R4 unlock gap sweep
    for (int d = 1; d <= 24; d++) begin
      idle(260);
      p0 = npulse;
      wr(O_UNLK, 16'hC520); idle(d - 1); wr(O_UNLK, 16'hD928); idle(2);
      check($sformatf("R4 unlock gap %0d faults", d), npulse - p0, (d <= 20) ? 0 : 2);
      wr(O_WINL, 16'(100 + d));
      if (d <= 20) winv = 16'(100 + d);
      rd(O_WINL, v); check($sformatf("R2 unlock gap %0d access", d), v, winv);
    end

    // R4 stray values
    idle(260); p0 = npulse;
    wr(O_UNLK, 16'h1234); idle(2);
    check("R4 wrong word", npulse - p0, 1);
    p0 = npulse; wr(O_UNLK, 16'hD928); idle(2);
    check("R4 second word alone", npulse - p0, 1);

    // R2 window edge: 256 accepted, 257 ignored
    unlock(); idle(255);
    wr(O_WINL, 16'h0AAA); wr(O_WINL, 16'h0BBB);
    rd(O_WINL, v); check("R2 unlock window end", v, 16'h0AAA);

    // R5 refresh gap sweep
    for (int d = 1; d <= 24; d++) begin
      p0 = npulse;
      wr(O_RFSH, 16'hA602); idle(d - 1); wr(O_RFSH, 16'hB480);
      if (d <= 20) begin
        rd(O_CNTL, v); check($sformatf("R5 refresh gap %0d clears", d), v, 0);
      end
      idle(2);
      check($sformatf("R5 refresh gap %0d faults", d), npulse - p0, (d <= 20) ? 0 : 2);
    end
    p0 = npulse; wr(O_RFSH, 16'h0042); idle(2);
    check("R5 wrong word", npulse - p0, 1);

    // R7 / R8 timeout grid
    for (int p = 0; p <= 3; p++)
      for (int t = 1; t <= 4; t++)
        for (int m = 0; m <= 1; m++) begin
          unlock();
          wr(O_CTL, 16'h0010);
          refresh();
          wr(O_TMOH, 16'h0); wr(O_TMOL, 16'(t)); wr(O_PRE, 16'(p));
          wr(O_CTL, (m == 1) ? 16'h0015 : 16'h0011);
          k = 0; irq_k = -1;
          while (!wdt_rst_req && k < 200) begin
            @(negedge clk); k++;
            if (wdt_irq && irq_k < 0) irq_k = k;
          end
          lat  = k;
          expl = (m == 1) ? (p + 1) * t + ((p + 1 > 2) ? p + 1 : 2) : (p + 1) * t + 1;
          expi = (m == 1) ? (p + 1) * t + 1 : -1;
          rd(O_CNTL, v);
          if (m == 1) begin
            check($sformatf("R8 reset latency p%0d t%0d", p, t), lat, expl);
            check($sformatf("R8 irq latency p%0d t%0d", p, t), irq_k, expi);
          end else begin
            check($sformatf("R7 reset latency p%0d t%0d", p, t), lat, expl);
            check($sformatf("R7 no irq p%0d t%0d", p, t), irq_k, expi);
            check($sformatf("R7 counter cleared p%0d t%0d", p, t), v, 0);
          end
        end

    // R6 / R10 counting and halting
    unlock();
    wr(O_CTL, 16'h0010); refresh();
    wr(O_TMOH, 16'h0001); wr(O_PRE, 16'h0000); wr(O_CTL, 16'h0011);
    rd(O_CNTL, a0); idle(10); rd(O_CNTL, b0);
    check("R6 rate p0", b0 - a0, 10);
    wr(O_PRE, 16'h0002); rd(O_CNTL, a0); idle(30); rd(O_CNTL, b0);
    check("R6 rate p2", b0 - a0, 10);
    rd(O_CNTH, v); check("R6 high half", v, 0);
    wr(O_CTL, 16'h0010);
    rd(O_CNTL, a0); idle(10); rd(O_CNTL, b0);
    check("R10 halted", b0, a0);

    // R9 window sweep
    unlock();
    wr(O_PRE, 16'h0000); wr(O_WINH, 16'h0); wr(O_WINL, 16'd10);
    wr(O_CTL, 16'h0019);
    refresh();
    for (int n = 0; n <= 15; n++) begin
      idle(n); refresh();
      check($sformatf("R9 window refresh at count %0d", n + 1), wdt_rst_req, (n + 1 < 10) ? 1 : 0);
    end
    unlock(); wr(O_CTL, 16'h0010); idle(2);

    // R12 reset counter
    wr(O_RCNT, 16'hFFFF);
    rd(O_RCNT, v); check("R12 clear all", v, 0);
    p0 = npulse;
    for (int i = 0; i < 3; i++) begin
      wr(O_UNLK, 16'h1111); idle(1);
    end
    idle(2);
    rd(O_RCNT, v); check("R12 count", v, 3);
    check("R12 pulses", npulse - p0, 3);
    wr(O_RCNT, 16'h0001);
    rd(O_RCNT, v); check("R12 clear bit0", v, 2);

    // R11 single update
    unlock(); wr(O_CTL, 16'h0000); idle(260);
    p0 = npulse;
    unlock(); wr(O_WINL, 16'h0055); wr(O_UNLK, 16'h1234); idle(2);
    rd(O_WINL, v); check("R11 second unlock ignored", v, 16'd10);
    check("R11 no fault", npulse - p0, 0);
    rd(O_CTL, v); check("R11 ctl kept", v, 0);

    finish_run();
  end
endmodule